// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Controller

This block gathers up to 32 peripheral interrupt lines and turns them into one cascaded request for a host processor. Each line is edge-captured into a sticky pending bit. The line then takes part in priority selection when its mask bit is set and it is not already being serviced. The host programs a configuration word that holds a global enable, one promoted vector and a request level for the cascade line. It also programs a mask word.

To service an interrupt, the host writes the acknowledge bit of the vector register. That write freezes the winning vector number and marks the source as in service. The host then reads the vector register to get the number, runs its handler and writes a one to the source's bit in the in-service register. That write retires both the in-service and the pending state. Vector 0 is reserved. It is returned when an acknowledge finds nothing eligible, which happens when a source was masked between raising the request and being acknowledged.

Top module: `vic_irq_ctrl`

## Requirements
- R1: After reset the configuration, mask and in-service registers read 0, the vector register reads 0 and `irq_o` is low.
- R2: A low-to-high transition on `src_i[k]` sets pending bit k. The bit stays set while the line is held high or low, until it is retired. A line held high after retirement does not set the bit again.
- R3: Mask register (address 1) bit k set to 1 enables source k and 0 disables it. A disabled pending source does not raise `irq_o` and is not selected. It keeps its pending state and is serviced once it is enabled.
- R4: `irq_o` is high only while configuration bit 7 (global enable) is 1 and at least one enabled, pending source is not in service.
- R5: Among eligible sources, the higher vector number wins.
- R6: Configuration bits 12:8 name a promoted vector. If that vector is eligible, it wins over any other eligible source.
- R7: Writing address 3 with data bit 0 = 1 latches the winner into the vector register. A higher-priority source that becomes pending afterwards does not change the value read until the next acknowledge.
- R8: An acknowledge that finds a winner sets that vector's bit in the in-service register (address 2). An in-service source is excluded from selection.
- R9: Writing address 2 clears in-service and pending bit k for every data bit k that is 1. Bits written as 0 are left unchanged.
- R10: An acknowledge with no eligible source latches error vector 0 and sets no in-service bit.
- R11: Reading address 3 returns the latched vector in bits 15:11 and zeros elsewhere. `irq_lvl_o` follows configuration bits 15:13.
- R12: Input `src_i[0]` is ignored, because vector 0 is reserved for the error condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Peripheral interrupt lines, synchronous to clk |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 config, 1 mask, 2 in-service, 3 vector |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register, combinational |
| irq_o | output | 1 | Cascaded interrupt request |
| irq_lvl_o | output | 3 | Request level programmed for the cascade |

## Verification
A source edge presented before a clock edge becomes pending at that edge. From that point `irq_o` is due, so the bench raises lines on a falling edge and samples `irq_o` at the next falling edge. Register writes, acknowledges and in-service clears are committed on the rising edge of the cycle in which the strobe is held. The read path is combinational, so each read is sampled at the falling edge that follows the write. The bench models priority arithmetically: the promoted vector wins if it is eligible, otherwise the highest set bit wins. It sweeps every single source, every promoted-vector setting and several multi-source patterns that it drains until the error vector appears.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    RA_CFG   = 2'd0,
    RA_MASK  = 2'd1,
    RA_INSVC = 2'd2,
    RA_VEC   = 2'd3
  } reg_addr_e;

  // configuration word field positions
  localparam int CFG_GIE    = 7;
  localparam int CFG_HP_LSB = 8;
  localparam int CFG_LV_LSB = 13;
  localparam int LVL_W      = 3;
  localparam int VEC_REG_W  = 16;
endpackage

// File: rtl/vic_edge.sv
module vic_edge #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  for (genvar k = 0; k < N; k++) begin : g_bit
    if (k == 0) begin : g_reserved
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q[k] <= 1'b0;
        else        prev_q[k] <= 1'b0;
      end
      assign rise_o[k] = 1'b0;
    end else begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q[k] <= 1'b0;
        else        prev_q[k] <= src_i[k];
      end
      assign rise_o[k] = src_i[k] & ~prev_q[k];
    end
  end
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int N  = 32,
  parameter int VW = $clog2(N)
) (
  input  logic [N-1:0]  elig_i,
  input  logic [VW-1:0] hp_i,
  output logic [VW-1:0] sel_o,
  output logic          valid_o
);
  function automatic logic [VW-1:0] top_index(input logic [N-1:0] v);
    logic [VW-1:0] idx;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (v[i]) idx = VW'(i);
    end
    return idx;
  endfunction

  logic hp_hit;
  assign hp_hit  = elig_i[hp_i];
  assign valid_o = |elig_i;
  assign sel_o   = hp_hit ? hp_i : top_index(elig_i);
endmodule

// File: rtl/vic_state.sv
module vic_state #(
  parameter int N  = 32,
  parameter int VW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  rise_i,
  input  logic [N-1:0]  clr_i,
  input  logic          ack_i,
  input  logic          valid_i,
  input  logic [VW-1:0] sel_i,
  output logic [N-1:0]  pend_o,
  output logic [N-1:0]  insvc_o,
  output logic [VW-1:0] vec_o
);
  logic [N-1:0] take;

  for (genvar k = 0; k < N; k++) begin : g_bit
    assign take[k] = ack_i & valid_i & (sel_i == VW'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pend_o[k] <= 1'b0;
      else if (rise_i[k]) pend_o[k] <= 1'b1;
      else if (clr_i[k])  pend_o[k] <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        insvc_o[k] <= 1'b0;
      else if (clr_i[k]) insvc_o[k] <= 1'b0;
      else if (take[k])  insvc_o[k] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vec_o <= '0;
    else if (ack_i) vec_o <= valid_i ? sel_i : '0;
  end
endmodule

// File: rtl/vic_irq_ctrl.sv
module vic_irq_ctrl
  import vic_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq_o,
  output logic [LVL_W-1:0]  irq_lvl_o
);
  localparam int VW      = $clog2(NSRC);
  localparam int VEC_LSB = VEC_REG_W - VW;

  logic             gie;
  logic [VW-1:0]    hp;
  logic [LVL_W-1:0] lvl;
  logic [NSRC-1:0]  mask_q;
  logic [NSRC-1:0]  rise, pend, insvc, elig, clr_bits;
  logic [VW-1:0]    sel_vec, vec_q;
  logic             sel_valid, ack_evt;

  assign ack_evt  = bus_we && (bus_addr == RA_VEC) && bus_wdata[0];
  assign clr_bits = (bus_we && (bus_addr == RA_INSVC)) ? bus_wdata[NSRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie    <= 1'b0;
      hp     <= '0;
      lvl    <= '0;
      mask_q <= '0;
    end else if (bus_we) begin
      if (bus_addr == RA_CFG) begin
        gie <= bus_wdata[CFG_GIE];
        hp  <= bus_wdata[CFG_HP_LSB +: VW];
        lvl <= bus_wdata[CFG_LV_LSB +: LVL_W];
      end
      if (bus_addr == RA_MASK) mask_q <= bus_wdata[NSRC-1:0];
    end
  end

  vic_edge #(.N(NSRC)) i_edge (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .rise_o(rise)
  );

  assign elig = pend & mask_q & ~insvc & ~NSRC'(1);

  vic_prio #(.N(NSRC), .VW(VW)) i_prio (
    .elig_i(elig), .hp_i(hp), .sel_o(sel_vec), .valid_o(sel_valid)
  );

  vic_state #(.N(NSRC), .VW(VW)) i_state (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .clr_i(clr_bits),
    .ack_i(ack_evt), .valid_i(sel_valid), .sel_i(sel_vec),
    .pend_o(pend), .insvc_o(insvc), .vec_o(vec_q)
  );

  assign irq_o     = gie & sel_valid;
  assign irq_lvl_o = lvl;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RA_CFG: begin
        bus_rdata[CFG_GIE]              = gie;
        bus_rdata[CFG_HP_LSB +: VW]     = hp;
        bus_rdata[CFG_LV_LSB +: LVL_W]  = lvl;
      end
      RA_MASK:  bus_rdata[NSRC-1:0] = mask_q;
      RA_INSVC: bus_rdata[NSRC-1:0] = insvc;
      default:  bus_rdata[VEC_LSB +: VW] = vec_q;
    endcase
  end
endmodule

// File: rtl/vic_irq_ctrl_chk.sv
module vic_irq_ctrl_chk #(
  parameter int N  = 32,
  parameter int VW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_o,
  input logic          gie,
  input logic          ack_evt,
  input logic          sel_valid,
  input logic [VW-1:0] vec_q,
  input logic [N-1:0]  insvc,
  input logic [N-1:0]  pend,
  input logic [N-1:0]  clr_bits
);
  // R4: request only under global enable and a selectable source
  a_r4_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (gie && sel_valid));

  // R7: latched vector moves only on an acknowledge
  a_r7_vec_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_evt |=> $stable(vec_q));

  // R10: empty acknowledge yields vector 0 and leaves in-service alone
  a_r10_err_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_evt && !sel_valid && clr_bits == '0) |=> (vec_q == '0 && $stable(insvc)));

  // R8: at most one in-service bit gained per cycle
  a_r8_one_gain: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $onehot0(insvc & ~$past(insvc)));

  // R2 / R9: pending bit drops only when retired
  a_r2_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pend) & ~$past(clr_bits)) & ~pend) == '0));

  // R12: reserved vector never pending
  a_r12_no_src0: assert property (@(posedge clk) disable iff (!rst_n)
    !pend[0]);
endmodule

bind vic_irq_ctrl vic_irq_ctrl_chk #(.N(NSRC), .VW($clog2(NSRC))) i_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .gie(gie), .ack_evt(ack_evt),
  .sel_valid(sel_valid), .vec_q(vec_q), .insvc(insvc), .pend(pend),
  .clr_bits(clr_bits)
);

// File: tb/test_vic_irq_ctrl.sv
module test_vic_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic [2:0]  irq_lvl_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  vic_irq_ctrl i_vic_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .irq_lvl_o(irq_lvl_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic set_src(input logic [31:0] v);
    @(negedge clk);
    src_i = v;
    @(negedge clk);
  endtask

  function automatic logic [31:0] cfg_word(input logic g, input int h, input int l);
    return (32'(g) << 7) | (32'(h) << 8) | (32'(l) << 13);
  endfunction

  // model: promoted vector wins if eligible, else highest set bit, 0 if none
  function automatic int expect_vec(input logic [31:0] e, input int h);
    int r;
    e[0] = 1'b0;
    if (e[h]) return h;
    r = 0;
    for (int i = 31; i >= 1; i--) if (e[i] && r == 0) r = i;
    return r;
  endfunction

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] pat, live;
    int e;
    logic [31:0] pats [4];
    pats[0] = 32'hFFFF_FFFE; pats[1] = 32'h8421_0842;
    pats[2] = 32'h0000_F00F; pats[3] = 32'h5A5A_A5A5;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    rd(2'd0, d); check("R1 cfg", d, 0);
    rd(2'd1, d); check("R1 mask", d, 0);
    rd(2'd2, d); check("R1 insvc", d, 0);
    rd(2'd3, d); check("R1 vec", d, 0);
    check("R1 irq", {31'b0, irq_o}, 0);

    // R11 config readback and level output
    wr(2'd0, cfg_word(1'b1, 0, 5));
    rd(2'd0, d); check("R11 cfg readback", d, cfg_word(1'b1, 0, 5));
    check("R11 level", {29'b0, irq_lvl_o}, 5);
    wr(2'd1, 32'hFFFF_FFFF);

    // single-source sweep: R2 R5 R8 R9 R11
    for (int v = 1; v < 32; v++) begin
      set_src(32'h1 << v);
      check("R2 irq on edge", {31'b0, irq_o}, 1);
      wr(2'd3, 32'h1);
      rd(2'd3, d); check("R11 vector field", d, 32'(v) << 11);
      rd(2'd2, d); check("R8 insvc set", d, 32'h1 << v);
      check("R8 insvc excluded", {31'b0, irq_o}, 0);
      wr(2'd2, 32'h0);
      rd(2'd2, d); check("R9 write zero ignored", d, 32'h1 << v);
      wr(2'd2, 32'h1 << v);
      rd(2'd2, d); check("R9 clear", d, 0);
      check("R2 held level no retrigger", {31'b0, irq_o}, 0);
      set_src(32'h0);
    end

    // R12 source 0 ignored
    set_src(32'h1);
    check("R12 src0 irq", {31'b0, irq_o}, 0);
    wr(2'd3, 32'h1);
    rd(2'd3, d); check("R12 src0 vec", d, 0);
    set_src(32'h0);

    // R6 promoted vector sweep with all sources pending
    for (int h = 0; h < 32; h++) begin
      wr(2'd0, cfg_word(1'b1, h, 0));
      set_src(32'h0);
      set_src(32'hFFFF_FFFF);
      wr(2'd3, 32'h1);
      e = (h == 0) ? 31 : h;
      rd(2'd3, d); check("R6 promoted", d, 32'(e) << 11);
      wr(2'd2, 32'h1 << e);
    end
    wr(2'd2, 32'hFFFF_FFFF);
    set_src(32'h0);

    // R5 R8 R10 pattern drain under varied masks
    for (int p = 0; p < 4; p++) begin
      logic [31:0] m;
      m = (p[0]) ? 32'hFFFF_FFFF : ~pats[(p + 1) % 4];
      wr(2'd0, cfg_word(1'b1, 3, 0));
      wr(2'd1, m);
      set_src(pats[p]);
      live = pats[p] & m;
      for (int k = 0; k < 33; k++) begin
        e = expect_vec(live, 3);
        check("R5 irq level", {31'b0, irq_o}, (e != 0) ? 1 : 0);
        wr(2'd3, 32'h1);
        rd(2'd3, d); check("R5 drain order", d, 32'(e) << 11);
        if (e == 0) break;
        live[e] = 1'b0;
      end
      rd(2'd2, d); check("R10 no insvc from error", d, pats[p] & m & 32'hFFFF_FFFE);
      wr(2'd2, 32'hFFFF_FFFF);
      set_src(32'h0);
    end
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd0, cfg_word(1'b1, 0, 0));

    // R7 freeze against later higher source
    set_src(32'h1 << 5);
    wr(2'd3, 32'h1);
    set_src((32'h1 << 5) | (32'h1 << 20));
    rd(2'd3, d); check("R7 frozen", d, 32'd5 << 11);
    check("R7 irq for new source", {31'b0, irq_o}, 1);
    wr(2'd3, 32'h1);
    rd(2'd3, d); check("R7 next ack", d, 32'd20 << 11);
    wr(2'd2, 32'hFFFF_FFFF);
    set_src(32'h0);

    // R4 global enable gating
    wr(2'd0, cfg_word(1'b0, 0, 0));
    set_src(32'h1 << 7);
    check("R4 gie off", {31'b0, irq_o}, 0);
    wr(2'd0, cfg_word(1'b1, 0, 0));
    check("R4 gie on", {31'b0, irq_o}, 1);
    wr(2'd2, 32'h1 << 7);
    set_src(32'h0);

    // R3 and R10: masked race gives error vector, pending kept
    wr(2'd1, ~(32'h1 << 9));
    set_src(32'h1 << 9);
    check("R3 masked no irq", {31'b0, irq_o}, 0);
    wr(2'd3, 32'h1);
    rd(2'd3, d); check("R10 race error vector", d, 0);
    rd(2'd2, d); check("R10 no insvc", d, 0);
    wr(2'd1, 32'hFFFF_FFFF);
    check("R3 unmask serves", {31'b0, irq_o}, 1);
    wr(2'd3, 32'h1);
    rd(2'd3, d); check("R3 vector after unmask", d, 32'd9 << 11);
    rd(2'd1, d); check("R3 mask readback", d, 32'hFFFF_FFFF);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule